// File: doc/BRIEF.md
# Host Doorbell Port Decoder

This block sits on the host-bus side of a bus-mastering peripheral controller and acts as its doorbell. The host writes one byte to a single configured I/O port; the block recognises that write, decodes a two-bit command from the byte and emits a one-cycle strobe to clear the host interrupt, to start an operation, or to reset the board. Every recognised write also raises a level interrupt towards the on-board processor, which stays set until the processor acknowledges it.

The port address is a 16-bit configuration value. It can be compared over all sixteen bits, or over only the low eight bits when the host has a narrow I/O space. The same configured address also gives the memory location of the first host communication block: it is shifted left four places, and a page nibble selecting the first or the last megabyte of a 24-bit space is placed on top.

Top module: `doorbell_port_decoder`

## Requirements
- R1: After reset, clr_irq_o, start_o and board_rst_o are 0 and local_irq_o is 0.
- R2: With cfg_wide_io_i = 0, a write is recognised when io_addr_i[7:0] equals cfg_port_addr_i[7:0]. Bits 15:8 are not compared.
- R3: With cfg_wide_io_i = 1, a write is recognised only when all 16 bits of io_addr_i equal cfg_port_addr_i.
- R4: A read cycle (io_rd_i = 1 with io_wr_i = 0) to the port address produces no strobe and does not set local_irq_o.
- R5: A recognised write with io_data_i[1:0] = 0 pulses clr_irq_o high for exactly one cycle, in the cycle after the write edge.
- R6: A recognised write with io_data_i[1:0] = 1 pulses start_o high for exactly one cycle, in the cycle after the write edge.
- R7: A recognised write with io_data_i[1:0] = 2 pulses board_rst_o for one cycle only when cfg_hard_rst_en_i = 1. With the enable at 0 it has no effect on board_rst_o.
- R8: io_data_i[1:0] = 3 produces no strobe, and io_data_i[7:2] never affects which command is decoded.
- R9: board_rst_o is high in the cycle after any edge at which bus_init_i is high, whatever cfg_hard_rst_en_i is set to.
- R10: Every recognised write sets local_irq_o from the next cycle on. It stays set until an edge with irq_ack_i = 1 and no recognised write. When an acknowledge and a recognised write arrive at the same edge, the write wins.
- R11: blk_addr_o = {page, cfg_port_addr_i, 4'h0}, where page is 4'hF when cfg_page_hi_i = 1 and 4'h0 otherwise. All 16 port bits are used in both I/O modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_port_addr_i | input | 16 | Configured doorbell port address |
| cfg_wide_io_i | input | 1 | 1: compare 16 address bits; 0: compare the low 8 |
| cfg_page_hi_i | input | 1 | 1: block lies in the last megabyte; 0: in the first |
| cfg_hard_rst_en_i | input | 1 | Allows the reset command to reset the board |
| bus_init_i | input | 1 | Host bus initialise |
| io_wr_i | input | 1 | Host I/O write cycle |
| io_rd_i | input | 1 | Host I/O read cycle |
| io_addr_i | input | 16 | Host I/O address |
| io_data_i | input | 8 | Host write data |
| irq_ack_i | input | 1 | Processor acknowledge of the local interrupt |
| clr_irq_o | output | 1 | Clear-host-interrupt strobe |
| start_o | output | 1 | Start-operation strobe |
| board_rst_o | output | 1 | Board reset |
| local_irq_o | output | 1 | Interrupt to the on-board processor |
| blk_addr_o | output | 24 | Address of the first communication block |

## Verification
Two pairs of events can fall on the same edge. The first is a processor acknowledge arriving with a new doorbell write. The bench drives irq_ack_i and a matching write together and expects local_irq_o to stay at 1, then issues a lone acknowledge and expects 0. The second is bus_init_i arriving with a reset command while the enable is low. The bench drives both at one edge and expects board_rst_o high for that single following cycle.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  typedef enum logic [1:0] {
    CMD_CLEAR = 2'd0,
    CMD_START = 2'd1,
    CMD_RESET = 2'd2,
    CMD_RSVD  = 2'd3
  } db_cmd_e;

  typedef struct packed {
    logic clr;
    logic start;
    logic hard;
  } db_strobe_t;
endpackage

// File: rtl/db_addr_match.sv
module db_addr_match #(
  parameter int ADDR_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              match_o
);
  logic [ADDR_W-1:0] bit_ok;

  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    if (b < NARROW_W) begin : g_low
      assign bit_ok[b] = (cfg_addr_i[b] == bus_addr_i[b]);
    end else begin : g_high
      // upper bits only count in wide mode
      assign bit_ok[b] = !wide_i || (cfg_addr_i[b] == bus_addr_i[b]);
    end
  end

  assign match_o = &bit_ok;
endmodule

// File: rtl/db_cmd_decode.sv
module db_cmd_decode
  import doorbell_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              hard_en_i,
  output db_strobe_t        strobe_o
);
  db_cmd_e    cmd;
  db_strobe_t strobe_d, strobe_q;

  assign cmd = db_cmd_e'(data_i[1:0]);

  always_comb begin
    strobe_d = '0;
    if (hit_i) begin
      unique case (cmd)
        CMD_CLEAR: strobe_d.clr   = 1'b1;
        CMD_START: strobe_d.start = 1'b1;
        CMD_RESET: strobe_d.hard  = hard_en_i;
        CMD_RSVD:  strobe_d       = '0;
        default:   strobe_d       = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= '0;
    else         strobe_q <= strobe_d;
  end

  assign strobe_o = strobe_q;

  a_r5_strobe_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({strobe_q.clr, strobe_q.start, strobe_q.hard}));

  a_r4_strobe_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i == 1'b0 |=> strobe_q == '0);

  a_r7_hard_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hard_en_i |=> !strobe_q.hard);
endmodule

// File: rtl/db_irq_latch.sv
module db_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;  // new write beats ack
    else if (ack_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  a_r10_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> irq_q);

  a_r10_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !ack_i |=> irq_q);

  a_r10_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !set_i |=> !irq_q);
endmodule

// File: rtl/db_blk_addr.sv
module db_blk_addr #(
  parameter int ADDR_W  = 16,
  parameter int SHIFT   = 4,
  parameter int PAGE_W  = 4,
  localparam int BLK_W  = PAGE_W + ADDR_W + SHIFT
) (
  input  logic [ADDR_W-1:0] port_i,
  input  logic              page_hi_i,
  output logic [BLK_W-1:0]  blk_o
);
  logic [PAGE_W-1:0] page;
  assign page  = page_hi_i ? {PAGE_W{1'b1}} : {PAGE_W{1'b0}};
  assign blk_o = {page, port_i, {SHIFT{1'b0}}};
endmodule

// File: rtl/doorbell_port_decoder.sv
module doorbell_port_decoder
  import doorbell_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NARROW_W = 8,
  parameter int DATA_W   = 8,
  parameter int SHIFT    = 4,
  parameter int PAGE_W   = 4,
  localparam int BLK_W   = PAGE_W + ADDR_W + SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cfg_port_addr_i,
  input  logic              cfg_wide_io_i,
  input  logic              cfg_page_hi_i,
  input  logic              cfg_hard_rst_en_i,
  input  logic              bus_init_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [DATA_W-1:0] io_data_i,
  input  logic              irq_ack_i,
  output logic              clr_irq_o,
  output logic              start_o,
  output logic              board_rst_o,
  output logic              local_irq_o,
  output logic [BLK_W-1:0]  blk_addr_o
);
  logic       addr_hit;
  logic       wr_hit;
  logic       init_q;
  db_strobe_t strobe;

  db_addr_match #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_match (
    .cfg_addr_i (cfg_port_addr_i),
    .wide_i     (cfg_wide_io_i),
    .bus_addr_i (io_addr_i),
    .match_o    (addr_hit)
  );

  // reads never qualify, even with a matching address
  assign wr_hit = io_wr_i && addr_hit;

  db_cmd_decode #(.DATA_W(DATA_W)) u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (wr_hit),
    .data_i    (io_data_i),
    .hard_en_i (cfg_hard_rst_en_i),
    .strobe_o  (strobe)
  );

  db_irq_latch u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wr_hit),
    .ack_i  (irq_ack_i),
    .irq_o  (local_irq_o)
  );

  db_blk_addr #(.ADDR_W(ADDR_W), .SHIFT(SHIFT), .PAGE_W(PAGE_W)) u_blk (
    .port_i    (cfg_port_addr_i),
    .page_hi_i (cfg_page_hi_i),
    .blk_o     (blk_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_q <= 1'b0;
    else         init_q <= bus_init_i;
  end

  assign clr_irq_o   = strobe.clr;
  assign start_o     = strobe.start;
  assign board_rst_o = strobe.hard | init_q;

  a_r9_bus_init_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_init_i |=> board_rst_o);

  a_r4_read_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rd_i && !io_wr_i && !local_irq_o && !irq_ack_i |=> !local_irq_o && !start_o && !clr_irq_o);
endmodule

// File: tb/doorbell_port_decoder_tb.sv
module doorbell_port_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_port = 16'h1234;
  logic        cfg_wide = 1'b1;
  logic        cfg_page = 1'b0;
  logic        cfg_hard = 1'b0;
  logic        bus_init = 1'b0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_data = '0;
  logic        irq_ack = 1'b0;
  logic        clr_irq, start, board_rst, local_irq;
  logic [23:0] blk_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  doorbell_port_decoder u_dut (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .cfg_port_addr_i   (cfg_port),
    .cfg_wide_io_i     (cfg_wide),
    .cfg_page_hi_i     (cfg_page),
    .cfg_hard_rst_en_i (cfg_hard),
    .bus_init_i        (bus_init),
    .io_wr_i           (io_wr),
    .io_rd_i           (io_rd),
    .io_addr_i         (io_addr),
    .io_data_i         (io_data),
    .irq_ack_i         (irq_ack),
    .clr_irq_o         (clr_irq),
    .start_o           (start),
    .board_rst_o       (board_rst),
    .local_irq_o       (local_irq),
    .blk_addr_o        (blk_addr)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // strobes as a 4-bit word {clr, start, board_rst, irq}
  function automatic logic [3:0] outs();
    return {clr_irq, start, board_rst, local_irq};
  endfunction

  // drive one cycle at negedge; outputs of that edge are visible on return
  task automatic cycle(input logic wr, input logic rd, input logic [15:0] a,
                       input logic [7:0] d, input logic ack, input logic init);
    @(negedge clk);
    io_wr = wr; io_rd = rd; io_addr = a; io_data = d; irq_ack = ack; bus_init = init;
    @(negedge clk);
    io_wr = 0; io_rd = 0; irq_ack = 0; bus_init = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic clear_irq();
    cycle(0, 0, 16'h0, 8'h0, 1, 0);
  endtask

  task automatic t_reset();
    check("R1", "outputs after reset", {28'h0, outs()}, 32'h0);
  endtask

  task automatic t_blk_addr();
    cfg_port = 16'h0100; cfg_page = 0; #1;
    check("R11", "port 0100 page lo", blk_addr, 32'h001000);
    cfg_port = 16'h1234; #1;
    check("R11", "port 1234 page lo", blk_addr, 32'h012340);
    cfg_page = 1; #1;
    check("R11", "port 1234 page hi", blk_addr, 32'hF12340);
    cfg_wide = 0; #1;
    check("R11", "narrow mode keeps all bits", blk_addr, 32'hF12340);
    cfg_wide = 1; cfg_page = 0; #1;
  endtask

  task automatic t_wide_match();
    cfg_wide = 1; cfg_port = 16'h1234;
    cycle(1, 0, 16'h1234, 8'h01, 0, 0);
    check("R6", "start after matching write", {31'h0, start}, 1);
    idle();
    check("R6", "start single cycle", {31'h0, start}, 0);
    clear_irq();
    cycle(1, 0, 16'h5634, 8'h01, 0, 0);
    check("R3", "upper mismatch ignored in wide mode", {28'h0, outs()}, 32'h0);
  endtask

  task automatic t_narrow_match();
    cfg_wide = 0;
    cycle(1, 0, 16'h5634, 8'h01, 0, 0);
    check("R2", "narrow match ignores bits 15:8", {28'h0, outs()}, 32'b0101);
    clear_irq();
    cycle(1, 0, 16'h1235, 8'h01, 0, 0);
    check("R2", "low byte mismatch", {28'h0, outs()}, 32'h0);
    cfg_wide = 1;
  endtask

  task automatic t_read_ignored();
    cycle(0, 1, 16'h1234, 8'h01, 0, 0);
    check("R4", "read to port", {28'h0, outs()}, 32'h0);
  endtask

  task automatic t_clear_cmd();
    cycle(1, 0, 16'h1234, 8'hFC, 0, 0);
    check("R5", "clear strobe (upper data bits set)", {28'h0, outs()}, 32'b1001);
    idle();
    check("R5", "clear single cycle", {31'h0, clr_irq}, 0);
    clear_irq();
  endtask

  task automatic t_reset_cmd();
    cfg_hard = 0;
    cycle(1, 0, 16'h1234, 8'h02, 0, 0);
    check("R7", "reset cmd disabled", {28'h0, outs()}, 32'b0001);
    clear_irq();
    cfg_hard = 1;
    cycle(1, 0, 16'h1234, 8'h02, 0, 0);
    check("R7", "reset cmd enabled", {28'h0, outs()}, 32'b0011);
    idle();
    check("R7", "reset single cycle", {31'h0, board_rst}, 0);
    clear_irq();
    cfg_hard = 0;
  endtask

  task automatic t_reserved_cmd();
    cycle(1, 0, 16'h1234, 8'h07, 0, 0);
    check("R8", "reserved cmd: irq only", {28'h0, outs()}, 32'b0001);
    cycle(1, 0, 16'h1234, 8'hA9, 0, 0);
    check("R8", "data 0xA9 decodes as start", {28'h0, outs()}, 32'b0101);
    clear_irq();
  endtask

  task automatic t_bus_init();
    cfg_hard = 0;
    cycle(0, 0, 16'h0, 8'h0, 0, 1);
    check("R9", "bus init resets", {31'h0, board_rst}, 1);
    idle();
    check("R9", "bus init released", {31'h0, board_rst}, 0);
    cycle(1, 0, 16'h1234, 8'h02, 0, 1);
    check("R9", "bus init with disabled reset cmd", {28'h0, outs()}, 32'b0011);
    clear_irq();
  endtask

  task automatic t_irq();
    cycle(1, 0, 16'h1234, 8'h03, 0, 0);
    check("R10", "irq set", {31'h0, local_irq}, 1);
    repeat (3) idle();
    check("R10", "irq held", {31'h0, local_irq}, 1);
    cycle(1, 0, 16'h1234, 8'h03, 1, 0);
    check("R10", "write beats ack", {31'h0, local_irq}, 1);
    clear_irq();
    check("R10", "ack clears", {31'h0, local_irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle();
    t_reset();
    t_blk_addr();
    t_wide_match();
    t_narrow_match();
    t_read_ignored();
    t_clear_cmd();
    t_reset_cmd();
    t_reserved_cmd();
    t_bus_init();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule